// File: doc/BRIEF.md
# Receive Packet Length and Frame Check Filter

This block sits in a receive path after framing and unstuffing have turned the line into a byte stream. It applies per-packet rules before the bytes go into a receive buffer. It counts the bytes of each packet and compares the count with a lower and an upper limit. It checks the trailing frame check sequence (FCS) with a 16-bit or a 32-bit CRC, and it either removes the FCS bytes or forwards them. Bad packets are marked on their last output beat. A short packet or an over-long packet gets the abort flag. A packet with a wrong check sequence gets the FCS error flag.

In raw mode the block stops treating the input as packets. It ignores the incoming delimiters and cuts the byte stream into fixed-length chunks. It then marks the first and last byte of each chunk itself. The mode and all limits are captured when a packet or chunk starts. They stay fixed until that packet or chunk ends, so software can change them at any time.

Both stream sides use valid/ready handshakes. A beat moves on a rising clock edge when valid and ready are both high. The input is ready whenever the single output register is empty or is being drained in the same cycle. While the output is stalled, the output beat stays unchanged and no input is taken. No byte is ever lost or repeated.

Top module: `rx_pkt_filter`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all output fields hold their values. Stalls never change the sequence of output beats.
- R2: The packet length is the number of accepted bytes from the start beat to the end beat, FCS bytes included. A packet whose length lies within the limits leaves with neither flag set.
- R3: The lower limit in force is the larger of `cfg_min_len` and a floor: 6 with a 32-bit FCS, 4 with a 16-bit FCS, 2 with FCS checking off. A shorter packet ends with an end beat that carries `out_abort`=1.
- R4: If `cfg_max_len` < `cfg_min_len`, every packet ends with `out_abort`=1.
- R5: When byte number `cfg_max_len`+1 of a packet arrives, the block at once emits an end beat with `out_abort`=1 and data 0x00. The rest of that packet, up to its input end beat, produces no output. The next packet is handled normally.
- R6: With checking on, `cfg_fcs16`=0 selects CRC-32 (reflected polynomial 0xEDB88320) and `cfg_fcs16`=1 selects CRC-16 (reflected polynomial 0x8408). Both are preset to all ones. The FCS is the ones' complement of the CRC over the payload, sent least significant byte first. A packet that is not aborted and whose FCS is wrong ends with `out_fcs_err`=1.
- R7: With checking on and `cfg_fcs_keep`=0, the 4 or 2 FCS bytes are left out of the output and the end flag sits on the last payload byte. With `cfg_fcs_keep`=1, every byte is forwarded.
- R8: With `cfg_fcs_off`=1, no check is made and nothing is removed. `cfg_fcs16` and `cfg_fcs_keep` have no effect.
- R9: With `cfg_raw`=1, the input sop/eop flags are ignored and every byte is forwarded. Output chunks are exactly `cfg_max_len` bytes long (1 if it is 0), with sop on the first byte and eop on the last. Neither flag is ever set.
- R10: `out_abort` and `out_fcs_err` are only ever high on a beat that has `out_eop`=1. `out_sop` marks the first output beat of each packet.
- R11: The configuration is captured when a packet or chunk starts. Changes made before it ends do not affect it.
- R12: In packet mode, bytes that arrive outside a packet without `in_sop` produce no output.
- R13: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First output beat of a packet or chunk |
| out_eop | output | 1 | Last output beat of a packet or chunk |
| out_abort | output | 1 | Packet failed a length rule (end beat only) |
| out_fcs_err | output | 1 | Packet failed the FCS check (end beat only) |
| cfg_min_len | input | 8 | Configured lower length limit in bytes |
| cfg_max_len | input | 16 | Upper length limit, or chunk length in raw mode |
| cfg_fcs_off | input | 1 | 1: no FCS checking or removal |
| cfg_fcs16 | input | 1 | 1: 16-bit FCS, 0: 32-bit FCS |
| cfg_fcs_keep | input | 1 | 1: forward FCS bytes, 0: remove them |
| cfg_raw | input | 1 | 1: raw chunking mode |

## Verification
A wrong byte count shows up at the ports in one of two ways. It moves the abort beat of an over-long packet away from byte `cfg_max_len`+1, or it flags a legal packet at its end beat. Either way it appears within one beat of the byte involved. A holding line that slips by one place shifts the payload by a byte or leaves an FCS byte in the output, and the first wrong beat appears as soon as the payload starts to leave. A wrong CRC state only shows on the end beat of a packet that is not aborted, so both widths are tested with a correct and with a corrupted check sequence. A configuration that is not held correctly is caught by changing the inputs in the middle of a packet.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  localparam int DW      = 8;
  localparam int MIN_W   = 8;
  localparam int MAX_W   = 16;
  localparam int CNT_W   = MAX_W + 1;
  localparam int HOLD_D  = 4;
  localparam int HOLD_SW = $clog2(HOLD_D + 1);

  localparam logic [15:0] POLY16 = 16'h8408;
  localparam logic [31:0] POLY32 = 32'hEDB88320;
  localparam logic [15:0] GOOD16 = 16'hF0B8;
  localparam logic [31:0] GOOD32 = 32'hDEBB20E3;

  typedef struct packed {
    logic [MIN_W-1:0] min_len;
    logic [MAX_W-1:0] max_len;
    logic             fcs_off;
    logic             fcs16;
    logic             fcs_keep;
    logic             raw;
  } rpf_cfg_t;

  // number of trailing bytes held back for removal
  function automatic logic [HOLD_SW-1:0] strip_depth(rpf_cfg_t c);
    if (c.fcs_off || c.fcs_keep) return '0;
    return c.fcs16 ? HOLD_SW'(2) : HOLD_SW'(4);
  endfunction

  function automatic logic [MIN_W-1:0] len_floor(rpf_cfg_t c);
    if (c.fcs_off) return MIN_W'(2);
    return c.fcs16 ? MIN_W'(4) : MIN_W'(6);
  endfunction
endpackage

// File: rtl/rpf_crc.sv
module rpf_crc #(
  parameter int         W    = 32,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc_nxt
);
  logic [W-1:0] crc_q;

  always_comb begin
    crc_nxt = start ? '1 : crc_q;
    for (int i = 0; i < 8; i++) begin
      if (crc_nxt[0] ^ din[i]) crc_nxt = (crc_nxt >> 1) ^ POLY;
      else                      crc_nxt = crc_nxt >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  crc_q <= '1;
    else if (en) crc_q <= crc_nxt;
  end

  // R6: the running remainder only moves on accepted packet bytes
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(crc_q));
endmodule

// File: rtl/rpf_hold.sv
module rpf_hold #(
  parameter int DEPTH = 4,
  parameter int DW    = 8,
  parameter int SW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] depth,
  output logic          full,
  output logic [DW-1:0] oldest
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] sr [DEPTH];
  logic [SW-1:0] fill;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  fill <= '0;
    else if (push && clear)      fill <= SW'(1);
    else if (push && fill < SW'(DEPTH)) fill <= fill + SW'(1);
    else if (clear)              fill <= '0;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) if (push) sr[0] <= din;
    end else begin : g_body
      always_ff @(posedge clk) if (push) sr[g] <= sr[g-1];
    end
  end

  always_comb begin
    idx    = IW'(depth - SW'(1));
    full   = (depth != '0) && (fill >= depth);
    oldest = (depth != '0 && depth <= SW'(DEPTH)) ? sr[idx] : '0;
  end

  // R7: occupancy changes only on push or clear
  a_r7_fill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !push && !clear |=> $stable(fill));
endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter
  import rpf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_abort,
  output logic             out_fcs_err,
  input  logic [MIN_W-1:0] cfg_min_len,
  input  logic [MAX_W-1:0] cfg_max_len,
  input  logic             cfg_fcs_off,
  input  logic             cfg_fcs16,
  input  logic             cfg_fcs_keep,
  input  logic             cfg_raw
);
  rpf_cfg_t cfg_in, cfg_q, cfg_c;
  logic in_pkt, dropping, sent_any;
  logic [CNT_W-1:0] cnt, cnt_nxt, chunk_len, max_ext, min_eff;
  logic acc, start, sent_base;
  logic [HOLD_SW-1:0] depth;
  logic hold_full, hold_full_eff, hold_push, hold_clear;
  logic [DW-1:0] hold_old;
  logic [15:0] crc16;
  logic [31:0] crc32;
  logic crc_en, crc_bad;
  logic emit, e_sop, e_eop, e_ab, e_fe;
  logic [DW-1:0] e_data;
  logic n_in_pkt, n_drop, n_sent;
  logic [CNT_W-1:0] n_cnt;
  logic [MIN_W-1:0] floor_v;

  assign cfg_in = '{min_len: cfg_min_len, max_len: cfg_max_len, fcs_off: cfg_fcs_off,
                    fcs16: cfg_fcs16, fcs_keep: cfg_fcs_keep, raw: cfg_raw};

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign start    = !in_pkt && (cfg_in.raw || in_sop);
  assign cfg_c    = in_pkt ? cfg_q : cfg_in;

  always_comb begin
    cnt_nxt       = start ? CNT_W'(1) : cnt + CNT_W'(1);
    max_ext       = {1'b0, cfg_c.max_len};
    chunk_len     = (cfg_c.max_len == '0) ? CNT_W'(1) : max_ext;
    floor_v       = len_floor(cfg_c);
    min_eff       = CNT_W'((cfg_c.min_len > floor_v) ? cfg_c.min_len : floor_v);
    depth         = strip_depth(cfg_c);
    hold_full_eff = hold_full && !start;
    sent_base     = start ? 1'b0 : sent_any;
    crc_bad       = cfg_c.fcs16 ? (crc16 != GOOD16) : (crc32 != GOOD32);
  end

  rpf_hold #(.DEPTH(HOLD_D), .DW(DW), .SW(HOLD_SW)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(hold_clear), .push(hold_push),
    .din(in_data), .depth(depth), .full(hold_full), .oldest(hold_old));

  rpf_crc #(.W(16), .POLY(POLY16)) u_crc16 (
    .clk(clk), .rst_n(rst_n), .start(start), .en(crc_en), .din(in_data), .crc_nxt(crc16));

  rpf_crc #(.W(32), .POLY(POLY32)) u_crc32 (
    .clk(clk), .rst_n(rst_n), .start(start), .en(crc_en), .din(in_data), .crc_nxt(crc32));

  // per-beat decision
  always_comb begin
    emit = 1'b0; e_data = in_data; e_sop = 1'b0; e_eop = 1'b0; e_ab = 1'b0; e_fe = 1'b0;
    n_in_pkt = in_pkt; n_drop = dropping; n_sent = sent_any; n_cnt = cnt;
    hold_push = 1'b0; hold_clear = 1'b0; crc_en = 1'b0;
    if (acc && (start || in_pkt)) begin
      if (cfg_c.raw) begin
        emit     = 1'b1;
        e_sop    = start;
        e_eop    = (cnt_nxt >= chunk_len);
        n_cnt    = cnt_nxt;
        n_in_pkt = !e_eop;
      end else if (dropping) begin
        if (in_eop) begin
          n_in_pkt = 1'b0;
          n_drop   = 1'b0;
        end
      end else begin
        crc_en     = 1'b1;
        hold_push  = 1'b1;
        hold_clear = start;
        n_cnt      = cnt_nxt;
        n_in_pkt   = !in_eop;
        e_sop      = !sent_base;
        if (cnt_nxt > max_ext) begin
          emit     = 1'b1;
          e_eop    = 1'b1;
          e_ab     = 1'b1;
          e_data   = '0;
          n_drop   = !in_eop;
          n_in_pkt = !in_eop;
        end else if (in_eop) begin
          emit   = 1'b1;
          e_eop  = 1'b1;
          e_data = (depth == '0) ? in_data : (hold_full_eff ? hold_old : '0);
          e_ab   = (cnt_nxt < min_eff) || (cfg_c.max_len < MAX_W'(cfg_c.min_len));
          e_fe   = !e_ab && !cfg_c.fcs_off && crc_bad;
        end else if (depth == '0 || hold_full_eff) begin
          emit   = 1'b1;
          e_data = (depth == '0) ? in_data : hold_old;
        end
        n_sent = sent_base || emit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      dropping <= 1'b0;
      sent_any <= 1'b0;
      cnt      <= '0;
      cfg_q    <= '0;
    end else begin
      in_pkt   <= n_in_pkt;
      dropping <= n_drop;
      sent_any <= n_sent;
      cnt      <= n_cnt;
      if (acc && start) cfg_q <= cfg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_sop     <= 1'b0;
      out_eop     <= 1'b0;
      out_abort   <= 1'b0;
      out_fcs_err <= 1'b0;
    end else if (emit) begin
      out_valid   <= 1'b1;
      out_data    <= e_data;
      out_sop     <= e_sop;
      out_eop     <= e_eop;
      out_abort   <= e_ab;
      out_fcs_err <= e_fe;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R10: status flags only travel on an end beat
  a_r10_flags_on_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_abort || out_fcs_err) |-> out_eop);

  // R1: a stalled beat is held unchanged
  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_data, out_sop, out_eop, out_abort, out_fcs_err}));

  // R5: the count of a live packet never passes max+1
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt && !cfg_q.raw |-> cnt <= {1'b0, cfg_q.max_len} + CNT_W'(1));

  // R9: an open raw chunk is always shorter than its length
  a_r9_chunk_open: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt && cfg_q.raw |-> cnt < ((cfg_q.max_len == '0) ? CNT_W'(1) : {1'b0, cfg_q.max_len}));

  // R11: captured settings stay put while a packet is open
  a_r11_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    in_pkt && $past(in_pkt) |-> $stable(cfg_q));
endmodule

// File: tb/test_rx_pkt_filter.sv
module test_rx_pkt_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop, out_abort, out_fcs_err;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic [7:0] c_min = '0;
  logic [15:0] c_max = 16'd100;
  logic c_off = 1'b0, c_f16 = 1'b0, c_keep = 1'b0, c_raw = 1'b0;

  int checks = 0, fails = 0;
  int stall_seen = 0, stall_bad = 0;
  bit stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  logic [7:0] tx_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] rx_d[$];
  bit rx_s[$], rx_e[$], rx_a[$], rx_f[$];

  always #10 clk = ~clk;

  rx_pkt_filter i_rx_pkt_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .out_abort(out_abort),
    .out_fcs_err(out_fcs_err), .cfg_min_len(c_min), .cfg_max_len(c_max),
    .cfg_fcs_off(c_off), .cfg_fcs16(c_f16), .cfg_fcs_keep(c_keep), .cfg_raw(c_raw));

  // sink: choose ready, then record the beat that moves at the next edge
  always @(negedge clk) begin
    out_ready = stall_en ? (lfsr[0] & lfsr[2]) : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #1;
    if (out_valid && !out_ready) begin
      stall_seen++;
      if (in_ready) stall_bad++;
    end
    if (out_valid && out_ready) begin
      rx_d.push_back(out_data); rx_s.push_back(out_sop); rx_e.push_back(out_eop);
      rx_a.push_back(out_abort); rx_f.push_back(out_fcs_err);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int mn, int mx, bit off, bit f16, bit keep, bit raw);
    c_min = 8'(mn); c_max = 16'(mx); c_off = off; c_f16 = f16; c_keep = keep; c_raw = raw;
  endtask

  task automatic put_byte(logic [7:0] d, bit s, bit e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic send_tx();
    for (int k = 0; k < tx_q.size(); k++) put_byte(tx_q[k], k == 0, k == tx_q.size() - 1);
  endtask

  task automatic drain(int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic clear_rx();
    rx_d.delete(); rx_s.delete(); rx_e.delete(); rx_a.delete(); rx_f.delete();
  endtask

  // payload of n bytes, then its FCS (LSB first) unless w == 0
  task automatic make_frame(int n, int seed, int w);
    logic [31:0] c;
    logic fb;
    tx_q.delete(); exp_q.delete();
    for (int k = 0; k < n; k++) begin
      tx_q.push_back(8'((seed + k * 37) ^ (k << 3)));
      exp_q.push_back(tx_q[k]);
    end
    if (w != 0) begin
      c = (w == 16) ? 32'h0000FFFF : 32'hFFFFFFFF;
      for (int k = 0; k < n; k++) begin
        for (int b = 0; b < 8; b++) begin
          fb = c[0] ^ tx_q[k][b];
          c = c >> 1;
          if (fb) c = c ^ ((w == 16) ? 32'h00008408 : 32'hEDB88320);
        end
      end
      c = ~c;
      for (int b = 0; b < w / 8; b++) tx_q.push_back(c[8*b +: 8]);
    end
  endtask

  task automatic check_pkt(string req, int n, bit ab, bit fe, bit use_data);
    check(rx_d.size() == n, req, "beat count", rx_d.size(), n);
    if (rx_d.size() == n) begin
      for (int i = 0; i < n; i++) begin
        check(rx_s[i] == (i == 0), req, $sformatf("sop beat %0d", i), rx_s[i], i == 0);
        check(rx_e[i] == (i == n - 1), req, $sformatf("eop beat %0d", i), rx_e[i], i == n - 1);
        check(rx_a[i] == (ab && i == n - 1), "R10", $sformatf("%s abort beat %0d", req, i),
              rx_a[i], ab && i == n - 1);
        check(rx_f[i] == (fe && i == n - 1), "R10", $sformatf("%s fcs_err beat %0d", req, i),
              rx_f[i], fe && i == n - 1);
        if (use_data && !(ab && i == n - 1) && i < exp_q.size())
          check(rx_d[i] == exp_q[i], req, $sformatf("data beat %0d", i), rx_d[i], exp_q[i]);
      end
    end
    clear_rx();
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R13", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R13", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_good_strip32();
    set_cfg(0, 100, 0, 0, 0, 0);
    make_frame(10, 5, 32); send_tx(); drain(6);
    check_pkt("R7", 10, 0, 0, 1);            // R2 R6: legal length and good CRC-32
  endtask

  task automatic t_good_keep16();
    set_cfg(0, 100, 0, 1, 1, 0);
    make_frame(5, 9, 16);
    exp_q = tx_q;
    send_tx(); drain(6);
    check_pkt("R6", 7, 0, 0, 1);             // R7: both FCS bytes forwarded
  endtask

  task automatic t_bad_fcs();
    set_cfg(0, 100, 0, 0, 0, 0);
    make_frame(8, 3, 32);
    tx_q[3] = tx_q[3] ^ 8'h10; exp_q[3] = tx_q[3];
    send_tx(); drain(6);
    check_pkt("R6", 8, 0, 1, 1);
    set_cfg(0, 100, 0, 1, 0, 0);
    make_frame(4, 77, 16);
    tx_q[5] = tx_q[5] ^ 8'h01;
    send_tx(); drain(6);
    check_pkt("R6", 4, 0, 1, 1);
  endtask

  task automatic t_fcs_off();
    set_cfg(0, 100, 1, 1, 0, 0);
    make_frame(5, 21, 0); send_tx(); drain(6);
    check_pkt("R8", 5, 0, 0, 1);
  endtask

  task automatic t_floor();
    set_cfg(0, 100, 0, 0, 0, 0);
    make_frame(1, 2, 32); send_tx(); drain(6);
    check_pkt("R3", 1, 1, 0, 0);             // 5 bytes under the 6 floor
    make_frame(2, 2, 32); send_tx(); drain(6);
    check_pkt("R3", 2, 0, 0, 1);             // exactly 6 passes
    set_cfg(0, 100, 0, 1, 0, 0);
    make_frame(1, 4, 16); send_tx(); drain(6);
    check_pkt("R3", 1, 1, 0, 0);             // 3 bytes under the 4 floor
    make_frame(2, 4, 16); send_tx(); drain(6);
    check_pkt("R3", 2, 0, 0, 1);
    set_cfg(0, 100, 1, 0, 0, 0);
    make_frame(1, 6, 0); send_tx(); drain(6);
    check_pkt("R3", 1, 1, 0, 0);             // 1 byte under the 2 floor
    make_frame(2, 6, 0); send_tx(); drain(6);
    check_pkt("R3", 2, 0, 0, 1);
    set_cfg(8, 100, 1, 0, 0, 0);
    make_frame(7, 8, 0); send_tx(); drain(6);
    check_pkt("R3", 7, 1, 0, 1);             // configured limit above the floor
    make_frame(8, 8, 0); send_tx(); drain(6);
    check_pkt("R2", 8, 0, 0, 1);
  endtask

  task automatic t_max_below_min();
    set_cfg(10, 9, 1, 0, 0, 0);
    make_frame(9, 1, 0); send_tx(); drain(6);
    check_pkt("R4", 9, 1, 0, 1);
    make_frame(10, 1, 0); send_tx(); drain(6);
    check_pkt("R4", 10, 1, 0, 1);
  endtask

  task automatic t_oversize();
    set_cfg(0, 8, 1, 0, 0, 0);
    make_frame(12, 40, 0); send_tx(); drain(6);
    if (rx_d.size() == 9) check(rx_d[8] == 8'h00, "R5", "abort beat data", rx_d[8], 0);
    check_pkt("R5", 9, 1, 0, 1);
    make_frame(8, 41, 0); send_tx(); drain(6);
    check_pkt("R5", 8, 0, 0, 1);             // exact max, after a dropped tail
    set_cfg(0, 8, 0, 0, 0, 0);
    make_frame(8, 42, 32); send_tx(); drain(6);
    check_pkt("R5", 5, 1, 0, 1);             // stripping path: 4 payload then abort
  endtask

  task automatic t_raw();
    set_cfg(0, 5, 0, 0, 0, 1);
    make_frame(15, 60, 0);
    for (int k = 0; k < 15; k++) put_byte(tx_q[k], k == 2, k == 3 || k == 7);
    drain(6);
    check(rx_d.size() == 15, "R9", "raw beat count", rx_d.size(), 15);
    if (rx_d.size() == 15) begin
      for (int i = 0; i < 15; i++) begin
        check(rx_d[i] == tx_q[i], "R9", "raw data", rx_d[i], tx_q[i]);
        check(rx_s[i] == (i % 5 == 0) && rx_e[i] == (i % 5 == 4), "R9", "raw delimiters",
              {rx_s[i], rx_e[i]}, {i % 5 == 0, i % 5 == 4});
        check(!rx_a[i] && !rx_f[i], "R9", "raw flags", {rx_a[i], rx_f[i]}, 0);
      end
    end
    clear_rx();
  endtask

  task automatic t_cfg_hold();
    set_cfg(0, 100, 1, 0, 0, 0);
    make_frame(6, 90, 0);
    put_byte(tx_q[0], 1'b1, 1'b0);
    set_cfg(12, 2, 0, 0, 0, 1);
    for (int k = 1; k < 6; k++) put_byte(tx_q[k], 1'b0, k == 5);
    drain(6);
    check_pkt("R11", 6, 0, 0, 1);
    set_cfg(0, 100, 1, 0, 0, 0);
  endtask

  task automatic t_idle_bytes();
    set_cfg(0, 100, 1, 0, 0, 0);
    put_byte(8'h11, 1'b0, 1'b0);
    put_byte(8'h22, 1'b0, 1'b1);
    put_byte(8'h33, 1'b0, 1'b0);
    drain(6);
    check(rx_d.size() == 0, "R12", "beats from stray bytes", rx_d.size(), 0);
    make_frame(3, 15, 0); send_tx(); drain(6);
    check_pkt("R12", 3, 0, 0, 1);
  endtask

  task automatic t_stall();
    set_cfg(0, 100, 0, 0, 0, 0);
    stall_seen = 0; stall_bad = 0;
    stall_en = 1'b1;
    make_frame(20, 33, 32); send_tx(); drain(60);
    stall_en = 1'b0;
    drain(4);
    check(stall_seen > 0, "R1", "stall cycles seen", stall_seen, 1);
    check(stall_bad == 0, "R1", "in_ready high during stall", stall_bad, 0);
    check_pkt("R1", 20, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #3;
    t_reset();
    rst_n = 1'b1;
    drain(2);
    t_good_strip32();
    t_good_keep16();
    t_bad_fcs();
    t_fcs_off();
    t_floor();
    t_max_below_min();
    t_oversize();
    t_raw();
    t_cfg_hold();
    t_idle_bytes();
    t_stall();
    summary();
    $finish;
  end
endmodule